// File: doc/BRIEF.md
# Dual-Channel Fixed-Peripheral DMA Engine

This block moves data for two independent channels between a peripheral register, whose address never changes, and a RAM buffer, whose address advances after every unit moved. Software programs each channel through a small write port. It sets a peripheral address, a RAM address, a 16-bit unit count and a mode word, and then arms the channel. Each trigger moves one unit. A trigger is either a software strobe or one hardware event line chosen by the mode word.

One shared bus-master engine performs every unit as two accesses. It first reads the source and then writes the destination, and each access holds a request until the bus acknowledges it. The engine is a three-state machine:
- `ENG_IDLE` goes to `ENG_READ` when the fixed-priority arbiter grants a channel. In that cycle the engine consumes the channel's pending trigger and latches its source address, destination address and unit size.
- `ENG_READ` goes to `ENG_WRITE` on acknowledge if the channel is still enabled. If the channel was disabled meanwhile, it goes back to `ENG_IDLE` instead.
- `ENG_WRITE` goes to `ENG_IDLE` on acknowledge, and steps the channel if the channel is still enabled.

When a channel's count reaches zero, the channel disarms itself and pulses its interrupt.

Top module: `dual_dma_ctrl`

## Requirements
- R1: A channel whose enable bit is 0 makes no bus access. Clearing enable also clears its armed state. A channel arms only through a control write with both bit 0 (enable) and bit 1 (start) set to 1.
- R2: Writes to a channel's peripheral address (select 1), RAM address (select 2), count (select 3) or mode (select 4) registers are ignored while that channel's enable bit is 0. The control register is select 0.
- R3: An armed channel that receives no trigger issues no bus request.
- R4: A unit transfer is triggered either by the channel's `sw_trig` bit or by `hw_evt[sel]`, where sel is bits 5:2 of the mode word. Pulses on any other `hw_evt` bit are ignored.
- R5: Each unit is a read request held until `bus_ack`, followed by a write request held until `bus_ack`. The address stays stable while a request waits.
- R6: Mode bit 0 selects the direction. A value of 0 reads the peripheral address and writes the RAM address; a value of 1 reads RAM and writes the peripheral.
- R7: After each completed unit, the RAM address grows by 1 (mode bit 1 = 0, byte) or by 2 (mode bit 1 = 1, word). The peripheral address stays the same, and the count drops by 1.
- R8: When the count reaches 0, the channel disarms, its interrupt is high for exactly one cycle, and no further unit runs.
- R9: When both channels have a pending trigger in the same cycle, channel 0 is served first.
- R10: A trigger that arrives while its channel's unit is in progress is remembered and served after that unit.
- R11: Clearing enable during a unit lets the outstanding access complete. No further access follows for that unit, and no interrupt is raised.
- R12: Each channel has its own registers and interrupt. Activity on one channel does not change the other's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_sel | input | 3 | Register select (0 control, 1 peripheral address, 2 RAM address, 3 count, 4 mode) |
| cfg_wdata | input | 16 | Write data |
| sw_trig | input | 2 | Software trigger strobe, one bit per channel |
| hw_evt | input | 16 | Hardware event lines |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_word | output | 1 | 1 = 16-bit unit, 0 = 8-bit unit |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` on a read |
| bus_ack | input | 1 | Access acknowledge |
| ch_armed | output | 2 | Start bit of each channel |
| dma_irq | output | 2 | Completion interrupt of each channel |

## Verification
The bench builds the block at its default parameters: 16-bit addresses and count, two channels and sixteen event lines. This keeps the priority case and every trigger-select value reachable. Short counts of 1 to 5 exercise the final-unit disarm repeatedly. Acknowledge latencies of 0 to 8 cycles open windows in which a second trigger or a disable can land in the middle of a unit.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int EVT_N = 16;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_PADDR = 3'd1;
    localparam logic [2:0] SEL_RADDR = 3'd2;
    localparam logic [2:0] SEL_COUNT = 3'd3;
    localparam logic [2:0] SEL_MODE  = 3'd4;

    typedef struct packed {
        logic [3:0] trig_sel;
        logic       word;
        logic       to_periph;
    } mode_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              sw_trig,
    input  logic [EVT_N-1:0]  hw_evt,
    input  logic              take,
    input  logic              step,
    output logic              req,
    output logic              en,
    output logic              armed,
    output logic [AW-1:0]     paddr,
    output logic [AW-1:0]     raddr,
    output mode_t             mode,
    output logic              irq
);
    logic          en_q, start_q, pend_q, irq_q;
    logic [AW-1:0] paddr_q, raddr_q;
    logic [CW-1:0] cnt_q;
    mode_t         mode_q;
    logic          trig_hit;
    logic [AW-1:0] inc;

    assign trig_hit = start_q && (sw_trig || hw_evt[mode_q.trig_sel]);
    assign inc      = mode_q.word ? AW'(2) : AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
            pend_q  <= 1'b0;
            irq_q   <= 1'b0;
            paddr_q <= '0;
            raddr_q <= '0;
            cnt_q   <= '0;
            mode_q  <= '0;
        end else begin
            irq_q <= 1'b0;
            if (take)     pend_q <= 1'b0;
            if (trig_hit) pend_q <= 1'b1;
            if (step) begin
                raddr_q <= raddr_q + inc;
                cnt_q   <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    start_q <= 1'b0;
                    pend_q  <= 1'b0;
                    irq_q   <= 1'b1;
                end
            end
            if (cfg_we && en_q) begin
                unique case (cfg_sel)
                    SEL_PADDR: paddr_q <= cfg_wdata;
                    SEL_RADDR: raddr_q <= cfg_wdata;
                    SEL_COUNT: cnt_q   <= cfg_wdata[CW-1:0];
                    SEL_MODE:  mode_q  <= mode_t'(cfg_wdata[5:0]);
                    default: ;
                endcase
            end
            if (cfg_we && cfg_sel == SEL_CTRL) begin
                en_q    <= cfg_wdata[0];
                start_q <= cfg_wdata[0] & cfg_wdata[1];
                if (!(cfg_wdata[0] && cfg_wdata[1])) pend_q <= 1'b0;
            end
        end
    end

    assign req   = pend_q && start_q;
    assign en    = en_q;
    assign armed = start_q;
    assign paddr = paddr_q;
    assign raddr = raddr_q;
    assign mode  = mode_q;
    assign irq   = irq_q;

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    assert_irq_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !start_q);
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!start_q && !pend_q));
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cfg_we) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_comb begin
        assert_grant_onehot_R9: assert ($onehot0(grant));
    end

    generate
        for (genvar g = 1; g < NCH; g++) begin : g_prio
            always_comb begin
                assert_low_first_R9: assert (!(grant[g] && (|req[g-1:0])));
            end
        end
    endgenerate
endmodule

// File: rtl/dmac_eng.sv
module dmac_eng
    import dmac_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 16,
    parameter int DW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          grant,
    input  logic [NCH-1:0]          en_a,
    input  logic [NCH-1:0][AW-1:0]  paddr_a,
    input  logic [NCH-1:0][AW-1:0]  raddr_a,
    input  mode_t [NCH-1:0]         mode_a,
    output logic [NCH-1:0]          take,
    output logic [NCH-1:0]          step,
    output logic                    bus_req,
    output logic                    bus_we,
    output logic                    bus_word,
    output logic [AW-1:0]           bus_addr,
    output logic [DW-1:0]           bus_wdata,
    input  logic [DW-1:0]           bus_rdata,
    input  logic                    bus_ack
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    eng_state_e    state_q, state_nx;
    logic [CHW-1:0] cur_q, gidx;
    logic [AW-1:0]  src_q, dst_q;
    logic           word_q;
    logic [DW-1:0]  data_q;

    always_comb begin
        gidx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (grant[i]) gidx = CHW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ENG_IDLE:  if (|grant) state_nx = ENG_READ;
            ENG_READ:  if (bus_ack) state_nx = en_a[cur_q] ? ENG_WRITE : ENG_IDLE;
            ENG_WRITE: if (bus_ack) state_nx = ENG_IDLE;
            default:   state_nx = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            word_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (state_q == ENG_IDLE && (|grant)) begin
                cur_q  <= gidx;
                word_q <= mode_a[gidx].word;
                src_q  <= mode_a[gidx].to_periph ? raddr_a[gidx] : paddr_a[gidx];
                dst_q  <= mode_a[gidx].to_periph ? paddr_a[gidx] : raddr_a[gidx];
            end
            if (state_q == ENG_READ && bus_ack) data_q <= bus_rdata;
        end
    end

    always_comb begin
        take     = '0;
        step     = '0;
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        bus_addr = src_q;
        unique case (state_q)
            ENG_IDLE: take = grant;
            ENG_READ: bus_req = 1'b1;
            ENG_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dst_q;
                if (bus_ack && en_a[cur_q]) step[cur_q] = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_wdata = data_q;
    assign bus_word  = word_q;

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);
    assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> $stable(bus_addr));
    assert_step_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|step) |-> (bus_we && bus_ack));
    assert_read_before_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> $past(bus_req && !bus_we && bus_ack));
endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl
    import dmac_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DW  = 16,
    parameter int NCH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_ch,
    input  logic [2:0]            cfg_sel,
    input  logic [AW-1:0]         cfg_wdata,
    input  logic [NCH-1:0]        sw_trig,
    input  logic [EVT_N-1:0]      hw_evt,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic                  bus_word,
    output logic [AW-1:0]         bus_addr,
    output logic [DW-1:0]         bus_wdata,
    input  logic [DW-1:0]         bus_rdata,
    input  logic                  bus_ack,
    output logic [NCH-1:0]        ch_armed,
    output logic [NCH-1:0]        dma_irq
);
    logic [NCH-1:0]         req_a, grant, take, step, en_a;
    logic [NCH-1:0][AW-1:0] paddr_a, raddr_a;
    mode_t [NCH-1:0]        mode_a;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dmac_chan #(.AW(AW), .CW(CW)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_we    (cfg_we && (int'(cfg_ch) == c)),
                .cfg_sel   (cfg_sel),
                .cfg_wdata (cfg_wdata),
                .sw_trig   (sw_trig[c]),
                .hw_evt    (hw_evt),
                .take      (take[c]),
                .step      (step[c]),
                .req       (req_a[c]),
                .en        (en_a[c]),
                .armed     (ch_armed[c]),
                .paddr     (paddr_a[c]),
                .raddr     (raddr_a[c]),
                .mode      (mode_a[c]),
                .irq       (dma_irq[c])
            );
        end
    endgenerate

    dmac_arb #(.NCH(NCH)) u_arb (
        .req   (req_a),
        .grant (grant)
    );

    dmac_eng #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .en_a      (en_a),
        .paddr_a   (paddr_a),
        .raddr_a   (raddr_a),
        .mode_a    (mode_a),
        .take      (take),
        .step      (step),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );
endmodule

// File: tb/sim_dual_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dual_dma_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_ch = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [1:0]  sw_trig = 2'b00;
    logic [15:0] hw_evt = 16'd0;
    logic        bus_req, bus_we, bus_word;
    logic [15:0] bus_addr, bus_wdata;
    logic [15:0] bus_rdata = 16'd0;
    logic        bus_ack = 1'b0;
    logic [1:0]  ch_armed, dma_irq;

    always #4 clk = ~clk;

    dual_dma_ctrl #(.AW(16), .CW(16), .DW(16), .NCH(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sw_trig(sw_trig), .hw_evt(hw_evt), .bus_req(bus_req),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .ch_armed(ch_armed), .dma_irq(dma_irq)
    );

    logic [15:0] mem [0:127];
    logic [15:0] plog [0:63];
    int checks = 0, fails = 0;
    int irq_cnt [0:1];
    int rd_n = 0, wr_n = 0, p_wr_n = 0, force_lat = 0, wait_c = 0;
    logic [15:0] last_wr_addr = 16'd0, first_rd_addr = 16'd0, pseq = 16'd0;
    logic saw_req = 1'b0, done = 1'b0;
    logic [1:0] irq_prev = 2'b00;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ram_at(input logic [15:0] base, input int k, input bit word);
        return base + 16'(k * (word ? 2 : 1));
    endfunction

    // bus slave and interrupt monitor
    initial begin
        irq_cnt[0] = 0; irq_cnt[1] = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req) begin
                saw_req = 1'b1;
                if (wait_c > 0) wait_c--;
                else begin
                    bus_ack = 1'b1;
                    wait_c = (force_lat > 0) ? force_lat : int'($urandom % 3);
                    if (bus_we) begin
                        wr_n++;
                        last_wr_addr = bus_addr;
                        if (bus_addr >= 16'h0080) begin
                            if (p_wr_n < 64) plog[p_wr_n] = bus_wdata;
                            p_wr_n++;
                        end else mem[bus_addr[6:0]] = bus_wdata;
                    end else begin
                        if (rd_n == 0) first_rd_addr = bus_addr;
                        rd_n++;
                        if (bus_addr >= 16'h0080) begin
                            bus_rdata = pseq;
                            pseq = pseq + 16'd1;
                        end else bus_rdata = mem[bus_addr[6:0]];
                    end
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (dma_irq[c]) begin
                    irq_cnt[c]++;
                    if (irq_prev[c]) chk("R8 irq width", 32'd2, 32'd1);
                end
            end
            irq_prev = dma_irq;
        end
    end

    task automatic wr(input bit ch, input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input bit ch, input logic [15:0] pa, input logic [15:0] ra,
                         input logic [15:0] cnt, input logic [15:0] md);
        wr(ch, 3'd0, 16'h0001);
        wr(ch, 3'd1, pa);
        wr(ch, 3'd2, ra);
        wr(ch, 3'd3, cnt);
        wr(ch, 3'd4, md);
        wr(ch, 3'd0, 16'h0003);
    endtask

    task automatic pulse_sw(input logic [1:0] m);
        @(negedge clk); sw_trig = m;
        @(negedge clk); sw_trig = 2'b00;
    endtask

    task automatic pulse_hw(input int b);
        @(negedge clk); hw_evt = 16'(1) << b;
        @(negedge clk); hw_evt = 16'd0;
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 6) begin
            @(negedge clk);
            if (bus_req) q = 0; else q++;
        end
    endtask

    initial begin
        int i0, i1;
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) mem[i] = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset bus_req", 32'(bus_req), 32'd0);
        chk("R8 reset irq", 32'(dma_irq), 32'd0);
        chk("R1 reset armed", 32'(ch_armed), 32'd0);

        // R3: armed, no trigger
        setup(1'b0, 16'h0090, 16'h0010, 16'd3, 16'h0000);
        saw_req = 1'b0;
        repeat (20) @(negedge clk);
        chk("R3 no request without trigger", 32'(saw_req), 32'd0);
        chk("R1 armed after ctrl write", 32'(ch_armed[0]), 32'd1);

        // R6/R7/R8: peripheral to RAM, byte steps
        pseq = 16'h0100; wr_n = 0; i0 = irq_cnt[0];
        for (int k = 0; k < 3; k++) begin
            pulse_sw(2'b01);
            wait_idle();
            if (k == 1) begin
                chk("R8 still armed mid-run", 32'(ch_armed[0]), 32'd1);
                chk("R8 no irq mid-run", 32'(irq_cnt[0]), 32'(i0));
            end
        end
        for (int k = 0; k < 3; k++)
            chk("R7 R6 byte dest data", 32'(mem[ram_at(16'h0010, k, 1'b0)]), 32'(16'h0100 + 16'(k)));
        chk("R8 irq once", 32'(irq_cnt[0]), 32'(i0 + 1));
        chk("R8 disarmed", 32'(ch_armed[0]), 32'd0);
        pulse_sw(2'b01);
        wait_idle();
        chk("R8 no unit after done", 32'(wr_n), 32'd3);

        // R4/R6/R12: channel 1 RAM to peripheral, word, hw event 5
        for (int k = 0; k < 3; k++) mem[ram_at(16'h0020, k, 1'b1)] = 16'hA000 + 16'(k);
        setup(1'b1, 16'h0088, 16'h0020, 16'd3, 16'h0017);
        saw_req = 1'b0; p_wr_n = 0; i0 = irq_cnt[0]; i1 = irq_cnt[1];
        pulse_hw(4);
        repeat (10) @(negedge clk);
        chk("R4 other event ignored", 32'(saw_req), 32'd0);
        for (int k = 0; k < 3; k++) begin
            pulse_hw(5);
            wait_idle();
        end
        for (int k = 0; k < 3; k++)
            chk("R6 R7 word source to periph", 32'(plog[k]), 32'(16'hA000 + 16'(k)));
        chk("R7 periph address fixed", 32'(last_wr_addr), 32'h88);
        chk("R8 irq ch1", 32'(irq_cnt[1]), 32'(i1 + 1));
        chk("R12 ch0 irq untouched", 32'(irq_cnt[0]), 32'(i0));

        // R9: both pending same cycle
        setup(1'b0, 16'h0090, 16'h0050, 16'd1, 16'h0000);
        setup(1'b1, 16'h0088, 16'h0058, 16'd1, 16'h0001);
        rd_n = 0; i0 = irq_cnt[0]; i1 = irq_cnt[1];
        pulse_sw(2'b11);
        wait_idle();
        chk("R9 channel 0 first", 32'(first_rd_addr), 32'h90);
        chk("R9 ch0 done", 32'(irq_cnt[0]), 32'(i0 + 1));
        chk("R9 ch1 done", 32'(irq_cnt[1]), 32'(i1 + 1));

        // R10: trigger during a unit is kept
        setup(1'b0, 16'h0090, 16'h0048, 16'd2, 16'h0000);
        force_lat = 4; wait_c = 4; pseq = 16'h0700; wr_n = 0; i0 = irq_cnt[0];
        pulse_sw(2'b01);
        repeat (2) @(negedge clk);
        chk("R5 request held while waiting", 32'(bus_req), 32'd1);
        pulse_sw(2'b01);
        wait_idle();
        force_lat = 0;
        chk("R10 both units ran", 32'(wr_n), 32'd2);
        chk("R10 second data", 32'(mem[7'h49]), 32'h701);
        chk("R10 irq", 32'(irq_cnt[0]), 32'(i0 + 1));

        // R11: disable mid-unit
        setup(1'b0, 16'h0090, 16'h0030, 16'd3, 16'h0000);
        force_lat = 8; wait_c = 8; rd_n = 0; wr_n = 0; i0 = irq_cnt[0];
        pulse_sw(2'b01);
        repeat (3) @(negedge clk);
        wr(1'b0, 3'd0, 16'h0000);
        wait_idle();
        force_lat = 0;
        chk("R11 read completed", 32'(rd_n), 32'd1);
        chk("R11 no write after disable", 32'(wr_n), 32'd0);
        chk("R11 no irq", 32'(irq_cnt[0]), 32'(i0));
        chk("R1 disarmed by disable", 32'(ch_armed[0]), 32'd0);
        saw_req = 1'b0;
        pulse_sw(2'b01);
        repeat (8) @(negedge clk);
        chk("R1 disabled channel silent", 32'(saw_req), 32'd0);

        // R2: address write while disabled ignored
        wr(1'b0, 3'd2, 16'h0060);
        wr(1'b0, 3'd0, 16'h0001);
        wr(1'b0, 3'd3, 16'd1);
        wr(1'b0, 3'd0, 16'h0003);
        wr_n = 0;
        pulse_sw(2'b01);
        wait_idle();
        chk("R2 old RAM address kept", 32'(last_wr_addr), 32'h30);
        chk("R2 one unit", 32'(wr_n), 32'd1);

        // random rounds
        for (int r = 0; r < 10; r++) begin
            automatic bit ch = 1'($urandom % 2);
            automatic int cnt = 1 + int'($urandom % 5);
            automatic bit word = 1'($urandom % 2);
            automatic bit dir = 1'($urandom % 2);
            automatic int sel = int'($urandom % 16);
            automatic bit use_hw = 1'($urandom % 2);
            automatic logic [15:0] base = 16'($urandom % 40);
            automatic logic [15:0] pa = 16'h0080 + 16'($urandom % 64);
            automatic logic [15:0] p0 = 16'h3000 + 16'(r * 32);
            automatic int ib;
            for (int i = 0; i < 12; i++) mem[base + 16'(i)] = 16'h5000 + 16'(r * 16 + i);
            pseq = p0; wr_n = 0; p_wr_n = 0; ib = irq_cnt[ch];
            setup(ch, pa, base, 16'(cnt), 16'(sel * 4 + (word ? 2 : 0) + (dir ? 1 : 0)));
            for (int k = 0; k < cnt; k++) begin
                if (use_hw) pulse_hw(sel);
                else pulse_sw(ch ? 2'b10 : 2'b01);
                wait_idle();
            end
            chk("R8 random irq", 32'(irq_cnt[ch]), 32'(ib + 1));
            chk("R8 random disarm", 32'(ch_armed[ch]), 32'd0);
            chk("R4 random unit count", 32'(wr_n), 32'(cnt));
            for (int k = 0; k < cnt; k++) begin
                if (!dir)
                    chk("R6 R7 random ram data", 32'(mem[7'(ram_at(base, k, word))]), 32'(p0 + 16'(k)));
                else
                    chk("R6 R7 random periph data", 32'(plog[k]),
                        32'(16'h5000 + 16'(r * 16) + 16'(k * (word ? 2 : 1))));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule